// File: doc/BRIEF.md
# Receive Frame Timeout Controller

This block supervises the receive side of a spread-spectrum modem and decides when a frame attempt is over. After the correlator reports that the spreading code is locked, the controller waits for the start-of-frame delimiter. An optional watchdog, clocked by symbol ticks, abandons the attempt if the delimiter does not arrive in time. Once the delimiter is seen, header modes that carry a length field make the controller wait for that field. It can then count received data bits down to zero and close the frame.

Whenever a frame attempt is abandoned or completes, the block emits a single-cycle return-to-acquire pulse and its state goes back to ACQUIRE. A header length of zero closes the frame at once, whatever the length-count enable says. If the correlator drops lock, the controller returns to ACQUIRE in any state without a pulse.

Top module: `rx_frame_guard`

## Requirements
- R1: After reset the state output reads ACQUIRE and the return pulse is low; the state encoding is ACQUIRE=0, WAIT_SFD=1, WAIT_LENGTH=2, DATA=3.
- R2: In ACQUIRE, a high acquisition input moves the state to WAIT_SFD on the next clock.
- R3: In WAIT_SFD, with the watchdog enabled and a nonzero limit T, the T-th symbol tick counted since entering WAIT_SFD returns the state to ACQUIRE with a return pulse in the same cycle.
- R4: In WAIT_SFD, with the watchdog enable low or a limit of 0, symbol ticks never cause a timeout and the state stays WAIT_SFD.
- R5: A delimiter strobe in WAIT_SFD moves the state to WAIT_LENGTH for header modes 2 and 3 and to DATA for modes 0 and 1. A delimiter strobe in the same cycle as the watchdog expiry wins over the expiry.
- R6: In WAIT_LENGTH, a valid nonzero length N with length counting enabled moves the state to DATA. The N-th data-bit strobe after that returns the state to ACQUIRE with a return pulse.
- R7: With length counting disabled, a valid nonzero length moves the state to DATA, and data-bit strobes never end it.
- R8: A valid length of 0 in WAIT_LENGTH returns the state to ACQUIRE with a return pulse, whatever the length-count enable.
- R9: In header modes 0 and 1, the DATA state persists for any number of data-bit strobes.
- R10: A low acquisition input in WAIT_SFD, WAIT_LENGTH or DATA returns the state to ACQUIRE on the next clock with no return pulse.
- R11: The return pulse lasts exactly one clock, and the state reads ACQUIRE whenever the pulse is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| acq_ok | input | 1 | Spreading-code acquisition achieved (level) |
| sym_tick | input | 1 | Symbol strobe that clocks the delimiter watchdog |
| sfd_hit | input | 1 | Start-of-frame delimiter detected (strobe) |
| len_word | input | LEN_W (16) | Header length field, in data bits |
| len_valid | input | 1 | Length field valid (strobe) |
| bit_tick | input | 1 | Received data bit strobe |
| hdr_mode | input | MODE_W (2) | Header mode 0..3 |
| sfd_tmo_en | input | 1 | Delimiter watchdog enable |
| len_tmo_en | input | 1 | Length countdown enable |
| sfd_tmo_val | input | TMO_W (16) | Watchdog limit in symbol ticks, 0 = off |
| reacq_pulse | output | 1 | One-cycle return-to-acquire pulse |
| state_o | output | 2 | Current supervisor state |

## Verification
The checker watches several rules on every clock. The pulse lasts one cycle and always coincides with ACQUIRE. A loss of lock leaves any state without a pulse. ACQUIRE exits on lock, the mode picks the branch after the delimiter, a zero length closes the frame, and a disabled watchdog keeps WAIT_SFD. The counted behaviour can only be shown by the bench's directed frames: the timeout firing on exactly the T-th symbol tick, the countdown ending on exactly the N-th bit, and the delimiter winning a tie with the expiry.

// File: rtl/rfg_pkg.sv
package rfg_pkg;
   typedef enum logic [1:0] {
      ST_ACQUIRE  = 2'd0,
      ST_WAIT_SFD = 2'd1,
      ST_WAIT_LEN = 2'd2,
      ST_DATA     = 2'd3
   } rfg_state_e;
endpackage

// File: rtl/rfg_sfd_timer.sv
module rfg_sfd_timer #(
   parameter int TMO_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             tick,
   input  logic             enable,
   input  logic [TMO_W-1:0] limit,
   output logic             expire
);
   localparam int CW = TMO_W + 1;

   logic [TMO_W-1:0] cnt;
   logic             active;
   logic [CW-1:0]    next_cnt;

   assign active   = enable && (limit != '0);
   assign next_cnt = {1'b0, cnt} + CW'(1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt <= '0;
      else if (!run)
         cnt <= '0;
      else if (active && tick && !next_cnt[TMO_W])
         cnt <= next_cnt[TMO_W-1:0];
   end

   // Fires on the tick that brings the count up to the limit.
   assign expire = run && active && tick && (next_cnt >= {1'b0, limit});
endmodule

// File: rtl/rfg_len_counter.sv
module rfg_len_counter #(
   parameter int LEN_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear,
   input  logic             load,
   input  logic [LEN_W-1:0] load_val,
   input  logic             tick,
   output logic             done
);
   logic [LEN_W-1:0] cnt;
   logic             armed;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt   <= '0;
         armed <= 1'b0;
      end else if (clear) begin
         armed <= 1'b0;
      end else if (load) begin
         cnt   <= load_val;
         armed <= 1'b1;
      end else if (armed && tick && cnt != '0) begin
         cnt <= cnt - LEN_W'(1);
      end
   end

   assign done = armed && tick && (cnt == LEN_W'(1));
endmodule

// File: rtl/rfg_fsm.sv
module rfg_fsm
   import rfg_pkg::*;
#(
   parameter int MODE_W   = 2,
   parameter bit SFD_WINS = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              acq_ok,
   input  logic              sfd_hit,
   input  logic              len_valid,
   input  logic              len_zero,
   input  logic [MODE_W-1:0] hdr_mode,
   input  logic              len_en,
   input  logic              tmo_expire,
   input  logic              len_done,
   output rfg_state_e        state,
   output logic              reacq_pulse,
   output logic              len_load
);
   rfg_state_e state_nx;
   logic       fire;
   logic       expire_eff;
   logic       mode_has_len;

   assign mode_has_len = (hdr_mode >= MODE_W'(2));

   generate
      if (SFD_WINS) begin : g_sfd_priority
         assign expire_eff = tmo_expire && !sfd_hit;
      end else begin : g_tmo_priority
         assign expire_eff = tmo_expire;
      end
   endgenerate

   always_comb begin
      state_nx = state;
      fire     = 1'b0;
      len_load = 1'b0;
      if (state != ST_ACQUIRE && !acq_ok) begin
         state_nx = ST_ACQUIRE;
      end else begin
         unique case (state)
            ST_ACQUIRE: if (acq_ok) state_nx = ST_WAIT_SFD;
            ST_WAIT_SFD: begin
               if (expire_eff) begin
                  fire     = 1'b1;
                  state_nx = ST_ACQUIRE;
               end else if (sfd_hit) begin
                  state_nx = mode_has_len ? ST_WAIT_LEN : ST_DATA;
               end
            end
            ST_WAIT_LEN: begin
               if (len_valid) begin
                  if (len_zero) begin
                     fire     = 1'b1;
                     state_nx = ST_ACQUIRE;
                  end else begin
                     len_load = len_en;
                     state_nx = ST_DATA;
                  end
               end
            end
            ST_DATA: begin
               if (len_done) begin
                  fire     = 1'b1;
                  state_nx = ST_ACQUIRE;
               end
            end
            default: state_nx = ST_ACQUIRE;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state       <= ST_ACQUIRE;
         reacq_pulse <= 1'b0;
      end else begin
         state       <= state_nx;
         reacq_pulse <= fire;
      end
   end
endmodule

// File: rtl/rx_frame_guard.sv
module rx_frame_guard
   import rfg_pkg::*;
#(
   parameter int TMO_W    = 16,
   parameter int LEN_W    = 16,
   parameter int MODE_W   = 2,
   parameter bit SFD_WINS = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              acq_ok,
   input  logic              sym_tick,
   input  logic              sfd_hit,
   input  logic [LEN_W-1:0]  len_word,
   input  logic              len_valid,
   input  logic              bit_tick,
   input  logic [MODE_W-1:0] hdr_mode,
   input  logic              sfd_tmo_en,
   input  logic              len_tmo_en,
   input  logic [TMO_W-1:0]  sfd_tmo_val,
   output logic              reacq_pulse,
   output logic [1:0]        state_o
);
   generate
      if (TMO_W < 1 || TMO_W > 32) begin : g_bad_tmo
         $error("rx_frame_guard: TMO_W must be 1..32");
      end
      if (LEN_W < 1 || LEN_W > 32) begin : g_bad_len
         $error("rx_frame_guard: LEN_W must be 1..32");
      end
      if (MODE_W < 2) begin : g_bad_mode
         $error("rx_frame_guard: MODE_W must be at least 2");
      end
   endgenerate

   rfg_state_e state;
   logic       tmo_expire;
   logic       len_done;
   logic       len_load;

   rfg_sfd_timer #(.TMO_W(TMO_W)) i_timer (
      .clk    (clk),
      .rst_n  (rst_n),
      .run    (state == ST_WAIT_SFD),
      .tick   (sym_tick),
      .enable (sfd_tmo_en),
      .limit  (sfd_tmo_val),
      .expire (tmo_expire)
   );

   rfg_len_counter #(.LEN_W(LEN_W)) i_len (
      .clk      (clk),
      .rst_n    (rst_n),
      .clear    (state == ST_ACQUIRE),
      .load     (len_load),
      .load_val (len_word),
      .tick     (bit_tick && state == ST_DATA),
      .done     (len_done)
   );

   rfg_fsm #(.MODE_W(MODE_W), .SFD_WINS(SFD_WINS)) i_fsm (
      .clk         (clk),
      .rst_n       (rst_n),
      .acq_ok      (acq_ok),
      .sfd_hit     (sfd_hit),
      .len_valid   (len_valid),
      .len_zero    (len_word == '0),
      .hdr_mode    (hdr_mode),
      .len_en      (len_tmo_en),
      .tmo_expire  (tmo_expire),
      .len_done    (len_done),
      .state       (state),
      .reacq_pulse (reacq_pulse),
      .len_load    (len_load)
   );

   assign state_o = state;
endmodule

// File: rtl/rfg_checker.sv
module rfg_checker #(
   parameter int TMO_W  = 16,
   parameter int LEN_W  = 16,
   parameter int MODE_W = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic              acq_ok,
   input logic              sfd_hit,
   input logic              sfd_tmo_en,
   input logic [TMO_W-1:0]  sfd_tmo_val,
   input logic              len_valid,
   input logic [LEN_W-1:0]  len_word,
   input logic [MODE_W-1:0] hdr_mode,
   input logic              reacq_pulse,
   input logic [1:0]        state_o
);
   a_r11_pulse_in_acquire: assert property (@(posedge clk) disable iff (!rst_n)
      reacq_pulse |-> state_o == 2'd0);

   a_r11_pulse_single: assert property (@(posedge clk) disable iff (!rst_n)
      reacq_pulse |=> !reacq_pulse);

   a_r10_lock_loss: assert property (@(posedge clk) disable iff (!rst_n)
      (!acq_ok && state_o != 2'd0) |=> (state_o == 2'd0 && !reacq_pulse));

   a_r2_leave_acquire: assert property (@(posedge clk) disable iff (!rst_n)
      (state_o == 2'd0 && acq_ok) |=> state_o == 2'd1);

   a_r4_watchdog_off: assert property (@(posedge clk) disable iff (!rst_n)
      (state_o == 2'd1 && acq_ok && !sfd_hit && (!sfd_tmo_en || sfd_tmo_val == '0))
      |=> state_o == 2'd1);

   a_r5_mode_branch: assert property (@(posedge clk) disable iff (!rst_n)
      (state_o == 2'd1 && acq_ok && sfd_hit)
      |=> state_o == ((hdr_mode >= MODE_W'(2)) ? 2'd2 : 2'd3));

   a_r8_zero_length: assert property (@(posedge clk) disable iff (!rst_n)
      (state_o == 2'd2 && acq_ok && len_valid && len_word == '0) |=> reacq_pulse);
endmodule

bind rx_frame_guard rfg_checker #(.TMO_W(TMO_W), .LEN_W(LEN_W), .MODE_W(MODE_W)) i_rfg_checker (
   .clk         (clk),
   .rst_n       (rst_n),
   .acq_ok      (acq_ok),
   .sfd_hit     (sfd_hit),
   .sfd_tmo_en  (sfd_tmo_en),
   .sfd_tmo_val (sfd_tmo_val),
   .len_valid   (len_valid),
   .len_word    (len_word),
   .hdr_mode    (hdr_mode),
   .reacq_pulse (reacq_pulse),
   .state_o     (state_o)
);

// File: tb/test_rx_frame_guard.sv
`timescale 1ns/1ps
module test_rx_frame_guard;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        acq_ok = 1'b0, sym_tick = 1'b0, sfd_hit = 1'b0;
   logic [15:0] len_word = '0;
   logic        len_valid = 1'b0, bit_tick = 1'b0;
   logic [1:0]  hdr_mode = 2'd0;
   logic        sfd_tmo_en = 1'b0, len_tmo_en = 1'b0;
   logic [15:0] sfd_tmo_val = '0;
   logic        reacq_pulse;
   logic [1:0]  state_o;
   int          checks = 0, failures = 0;
   bit          done = 1'b0;

   always #2.5 clk = ~clk;

   rx_frame_guard i_rx_frame_guard (
      .clk(clk), .rst_n(rst_n), .acq_ok(acq_ok), .sym_tick(sym_tick),
      .sfd_hit(sfd_hit), .len_word(len_word), .len_valid(len_valid),
      .bit_tick(bit_tick), .hdr_mode(hdr_mode), .sfd_tmo_en(sfd_tmo_en),
      .len_tmo_en(len_tmo_en), .sfd_tmo_val(sfd_tmo_val),
      .reacq_pulse(reacq_pulse), .state_o(state_o)
   );

   task automatic chk(input string req, input logic [1:0] exp_st, input logic exp_p);
      checks++;
      if (state_o !== exp_st || reacq_pulse !== exp_p) begin
         failures++;
         $display("FAIL %s: state=%0d pulse=%0b expected state=%0d pulse=%0b",
                  req, state_o, reacq_pulse, exp_st, exp_p);
      end
   endtask

   task automatic syms(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk) sym_tick = 1'b1;
         @(negedge clk) sym_tick = 1'b0;
      end
   endtask

   task automatic bits(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk) bit_tick = 1'b1;
         @(negedge clk) bit_tick = 1'b0;
      end
   endtask

   task automatic sfd();
      @(negedge clk) sfd_hit = 1'b1;
      @(negedge clk) sfd_hit = 1'b0;
   endtask

   task automatic give_len(input logic [15:0] v);
      @(negedge clk) begin len_word = v; len_valid = 1'b1; end
      @(negedge clk) len_valid = 1'b0;
   endtask

   task automatic lock();
      @(negedge clk) acq_ok = 1'b1;
      @(negedge clk);
   endtask

   task automatic unlock();
      @(negedge clk) acq_ok = 1'b0;
      @(negedge clk);
   endtask

   task automatic t_reset();
      chk("R1 reset", 2'd0, 1'b0);
   endtask

   task automatic t_sfd_timeout();
      hdr_mode = 2'd0; sfd_tmo_en = 1'b1; sfd_tmo_val = 16'd5;
      lock();
      chk("R2 enter WAIT_SFD", 2'd1, 1'b0);
      syms(4);
      chk("R3 before limit", 2'd1, 1'b0);
      syms(1);
      chk("R3 expiry at T-th tick", 2'd0, 1'b1);
      @(negedge clk);
      chk("R11 pulse one cycle", 2'd1, 1'b0);
      unlock();
   endtask

   task automatic t_sfd_disabled();
      sfd_tmo_en = 1'b0; sfd_tmo_val = 16'd3;
      lock();
      syms(10);
      chk("R4 enable low", 2'd1, 1'b0);
      sfd_tmo_en = 1'b1; sfd_tmo_val = 16'd0;
      syms(10);
      chk("R4 limit zero", 2'd1, 1'b0);
      unlock();
   endtask

   task automatic t_mode01();
      hdr_mode = 2'd1; sfd_tmo_en = 1'b0;
      lock();
      sfd();
      chk("R5 mode 1 to DATA", 2'd3, 1'b0);
      bits(20);
      chk("R9 DATA persists", 2'd3, 1'b0);
      unlock();
      chk("R10 lock loss in DATA", 2'd0, 1'b0);
   endtask

   task automatic t_len_count();
      hdr_mode = 2'd2; len_tmo_en = 1'b1;
      lock();
      sfd();
      chk("R5 mode 2 to WAIT_LENGTH", 2'd2, 1'b0);
      give_len(16'd3);
      chk("R6 enter DATA", 2'd3, 1'b0);
      bits(2);
      chk("R6 before last bit", 2'd3, 1'b0);
      bits(1);
      chk("R6 countdown end", 2'd0, 1'b1);
      unlock();
   endtask

   task automatic t_len_disabled();
      hdr_mode = 2'd3; len_tmo_en = 1'b0;
      lock();
      sfd();
      give_len(16'd2);
      bits(5);
      chk("R7 no countdown", 2'd3, 1'b0);
      unlock();
   endtask

   task automatic t_zero_len();
      hdr_mode = 2'd3; len_tmo_en = 1'b0;
      lock();
      sfd();
      give_len(16'd0);
      chk("R8 zero length", 2'd0, 1'b1);
      unlock();
   endtask

   task automatic t_tie();
      hdr_mode = 2'd0; sfd_tmo_en = 1'b1; sfd_tmo_val = 16'd2;
      lock();
      syms(1);
      @(negedge clk) begin sym_tick = 1'b1; sfd_hit = 1'b1; end
      @(negedge clk) begin sym_tick = 1'b0; sfd_hit = 1'b0; end
      chk("R5 delimiter beats expiry", 2'd3, 1'b0);
      unlock();
   endtask

   task automatic t_loss_wait_len();
      hdr_mode = 2'd2; sfd_tmo_en = 1'b0;
      lock();
      sfd();
      unlock();
      chk("R10 lock loss in WAIT_LENGTH", 2'd0, 1'b0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_sfd_timeout();
      t_sfd_disabled();
      t_mode01();
      t_len_count();
      t_len_disabled();
      t_zero_len();
      t_tie();
      t_loss_wait_len();
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         failures++;
         $display("FAIL watchdog: run did not finish, expected completion");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule